// File: doc/BRIEF.md
# Level-Masked Software Interrupt Register

This block keeps a 17-bit software interrupt register together with a 4-bit processor priority level, and presents one pending-interrupt line for every register bit. Bit 0 and bit 16 are timer-match bits. Bits 1 to 15 are software interrupt levels 1 to 15. Software changes the register in one of three ways: it can replace the register with a direct write, OR a value into it through a set alias, or clear selected bits through a clear alias. Software can also write the priority level.

The two timer bits and the fifteen level bits are masked differently. A timer bit is passed to its pending line only while the priority level is below 14. A level bit n is passed only when n is strictly greater than the priority level.

A one-cycle pulse from the system timer sets bit 16. The register and the priority level can always be read on dedicated outputs. The pending lines are combinational functions of the stored state, so they follow a write in the cycle after that write.

Top module: `soft_irq_mask`

## Requirements
- R1: After reset the register reads 0, the priority level reads 0, and every pending line is 0.
- R2: Pending line 0 is 1 exactly when register bit 0 is 1 and the level is below 14. Pending line 16 follows the same rule using register bit 16.
- R3: For n from 1 to 15, pending line n is 1 exactly when register bit n is 1 and n is greater than the level.
- R4: A write with `wrSel` = 1 (set alias) ORs `wrData[16:0]` into the register.
- R5: A write with `wrSel` = 2 (clear alias) clears each register bit whose `wrData` bit is 1 and leaves every other bit unchanged.
- R6: A write with `wrSel` = 0 (direct) replaces the register with `wrData[16:0]`.
- R7: A write with `wrSel` = 3 loads `wrData[3:0]` into the level and leaves the register unchanged. Every pending line is then evaluated against the new level.
- R8: `wrData` bits above bit 16 have no effect, and `rdReg` bits above bit 16 always read 0.
- R9: A `sysTickHit` pulse sets register bit 16. If a register write happens in the same cycle, the write is applied first and bit 16 is set afterwards, so the timer match is kept.
- R10: Register, level and pending outputs change only at the clock edge that captures a write. During the write cycle itself they still show the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 2 | Write target: 0 direct, 1 set alias, 2 clear alias, 3 level |
| wrData | input | 32 | Write data |
| sysTickHit | input | 1 | One-cycle system timer match pulse |
| rdReg | output | 32 | Register contents, zero-extended |
| rdLevel | output | 4 | Current priority level |
| pending | output | 17 | Masked pending-interrupt lines |

## Verification
The assertions assume that `wrSel` is stable and known whenever `wrEn` is high. They also assume that `sysTickHit` is a clean pulse sampled at the clock edge. The bench drives every input on the falling edge and keeps all inputs at defined values. It sweeps all sixteen levels against a walking one on every register bit, and it places timer pulses only in the same cycle as a write or in an otherwise idle cycle.

// File: rtl/soft_irq_pkg.sv
package soft_irq_pkg;

  typedef enum logic [1:0] {
    SEL_DIRECT = 2'd0,
    SEL_SET    = 2'd1,
    SEL_CLEAR  = 2'd2,
    SEL_LEVEL  = 2'd3
  } wrTarget_e;

  typedef struct packed {
    logic wrDirect;
    logic wrSet;
    logic wrClr;
    logic wrLevel;
    logic timerHit;
  } irqStrobes_t;

endpackage

// File: rtl/soft_irq_ctrl.sv
module soft_irq_ctrl
  import soft_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic        sysTickHit,
  output irqStrobes_t strobes
);

  wrTarget_e target;

  always_comb begin
    target           = wrTarget_e'(wrSel);
    strobes          = '0;
    strobes.timerHit = sysTickHit;
    if (wrEn) begin
      unique case (target)
        SEL_DIRECT: strobes.wrDirect = 1'b1;
        SEL_SET:    strobes.wrSet    = 1'b1;
        SEL_CLEAR:  strobes.wrClr    = 1'b1;
        SEL_LEVEL:  strobes.wrLevel  = 1'b1;
        default:    strobes          = strobes;
      endcase
    end
  end

  // R4 R5 R6 R7: a write drives exactly one action
  p_one_action_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $countones({strobes.wrDirect, strobes.wrSet, strobes.wrClr, strobes.wrLevel}) == 1);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(strobes.wrDirect || strobes.wrSet || strobes.wrClr || strobes.wrLevel));

endmodule

// File: rtl/soft_irq_datapath.sv
module soft_irq_datapath
  import soft_irq_pkg::*;
#(
  parameter int IRQ_W      = 17,
  parameter int LVL_W      = 4,
  parameter int TIMER_LOCK = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  irqStrobes_t      strobes,
  input  logic [IRQ_W-1:0] wrBits,
  output logic [IRQ_W-1:0] regQ,
  output logic [LVL_W-1:0] lvlQ,
  output logic [IRQ_W-1:0] pendOut
);

  localparam int HI_TIMER = IRQ_W - 1;

  logic [IRQ_W-1:0] regNext;
  logic             timersOpen;

  always_comb begin
    regNext = regQ;
    if (strobes.wrDirect) regNext = wrBits;
    if (strobes.wrSet)    regNext = regQ | wrBits;
    if (strobes.wrClr)    regNext = regQ & ~wrBits;
    if (strobes.timerHit) regNext[HI_TIMER] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regQ <= '0;
      lvlQ <= '0;
    end else begin
      regQ <= regNext;
      if (strobes.wrLevel) lvlQ <= wrBits[LVL_W-1:0];
    end
  end

  assign timersOpen = int'(lvlQ) < TIMER_LOCK;

  for (genvar i = 0; i < IRQ_W; i++) begin : g_mask
    if (i == 0 || i == HI_TIMER) begin : g_timer
      assign pendOut[i] = regQ[i] && timersOpen;
    end else begin : g_level
      assign pendOut[i] = regQ[i] && (i > int'(lvlQ));
    end
  end

  p_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrSet |=> (regQ & $past(wrBits)) == $past(wrBits));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrClr && !strobes.timerHit) |=> (regQ & $past(wrBits)) == '0);

  p_direct_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrDirect && !strobes.timerHit) |=> regQ == $past(wrBits));

  p_level_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrLevel |=> (lvlQ == $past(wrBits[LVL_W-1:0])) && $stable(regQ) || $past(strobes.timerHit));

  p_timer_kept_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.timerHit |=> regQ[HI_TIMER]);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.wrDirect || strobes.wrSet || strobes.wrClr || strobes.wrLevel || strobes.timerHit)
      |=> $stable(regQ) && $stable(lvlQ));

  p_timer_lock_r2: assert property (@(posedge clk) disable iff (!rstN)
    (lvlQ >= LVL_W'(TIMER_LOCK)) |-> !pendOut[0] && !pendOut[HI_TIMER]);

endmodule

// File: rtl/soft_irq_mask.sv
module soft_irq_mask
  import soft_irq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IRQ_W      = 17,
  parameter int LVL_W      = 4,
  parameter int TIMER_LOCK = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sysTickHit,
  output logic [DATA_W-1:0] rdReg,
  output logic [LVL_W-1:0]  rdLevel,
  output logic [IRQ_W-1:0]  pending
);

  localparam int PAD_W = DATA_W - IRQ_W;

  irqStrobes_t      strobes;
  logic [IRQ_W-1:0] regQ;
  logic             unusedBits;

  assign unusedBits = ^wrData[DATA_W-1:IRQ_W];

  soft_irq_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .sysTickHit (sysTickHit),
    .strobes    (strobes)
  );

  soft_irq_datapath #(
    .IRQ_W      (IRQ_W),
    .LVL_W      (LVL_W),
    .TIMER_LOCK (TIMER_LOCK)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrBits  (wrData[IRQ_W-1:0]),
    .regQ    (regQ),
    .lvlQ    (rdLevel),
    .pendOut (pending)
  );

  assign rdReg = {{PAD_W{1'b0}}, regQ};

  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdReg[DATA_W-1:IRQ_W] == '0);

endmodule

// File: tb/test_soft_irq_mask.sv
module test_soft_irq_mask;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [31:0] wrData = '0;
  logic        sysTickHit = 1'b0;
  logic [31:0] rdReg;
  logic [3:0]  rdLevel;
  logic [16:0] pending;

  int checks = 0;
  int errors = 0;
  logic [16:0] expReg = '0;
  logic [3:0]  expLvl = '0;

  always #5 clk = ~clk;

  soft_irq_mask i_soft_irq_mask (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .sysTickHit(sysTickHit), .rdReg(rdReg), .rdLevel(rdLevel), .pending(pending)
  );

  function automatic logic [16:0] modelPend(logic [16:0] r, logic [3:0] l);
    logic [16:0] p;
    for (int i = 0; i < 17; i++) begin
      if (i == 0 || i == 16) p[i] = r[i] && (l < 4'd14);
      else                   p[i] = r[i] && (i > int'(l));
    end
    return p;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    check(req, rdReg, {15'd0, expReg});
    check(req, {28'd0, rdLevel}, {28'd0, expLvl});
    check(req, {15'd0, pending}, {15'd0, modelPend(expReg, expLvl)});
  endtask

  // drive on falling edge, captured at next rising edge, sampled at next falling edge
  task automatic doWrite(logic [1:0] sel, logic [31:0] data, logic hit);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data; sysTickHit = hit;
    case (sel)
      2'd0: expReg = data[16:0];
      2'd1: expReg = expReg | data[16:0];
      2'd2: expReg = expReg & ~data[16:0];
      default: expLvl = data[3:0];
    endcase
    if (hit) expReg[16] = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; sysTickHit = 1'b0; wrData = '0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual hang expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAll("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after release");

    // R8: upper data bits ignored
    doWrite(2'd0, 32'hFFFF_FFFF, 1'b0);
    checkAll("R8 upper bits");
    doWrite(2'd0, 32'hABC0_0000, 1'b0);
    checkAll("R8 upper only");

    // R2 R3 R7: every level against a walking one and all ones
    for (int l = 0; l < 16; l++) begin
      doWrite(2'd3, 32'(l), 1'b0);
      checkAll("R7 level write");
      for (int b = 0; b < 17; b++) begin
        doWrite(2'd0, 32'(1) << b, 1'b0);
        if (b == 0 || b == 16) checkAll("R2 timer mask");
        else                   checkAll("R3 level mask");
      end
      doWrite(2'd0, 32'h1FFFF, 1'b0);
      checkAll("R6 direct all ones");
    end

    // R7: level change re-evaluates existing bits
    doWrite(2'd0, 32'h1C001, 1'b0);
    doWrite(2'd3, 32'd13, 1'b0);
    checkAll("R7 reevaluate 13");
    doWrite(2'd3, 32'd14, 1'b0);
    checkAll("R7 reevaluate 14");
    doWrite(2'd3, 32'd3, 1'b0);

    // R4 / R5 / R6
    doWrite(2'd0, 32'h00005, 1'b0);
    checkAll("R6 direct");
    doWrite(2'd1, 32'h10030, 1'b0);
    checkAll("R4 set alias");
    check("R4 set value", rdReg, 32'h10035);
    doWrite(2'd2, 32'h00011, 1'b0);
    checkAll("R5 clear alias");
    check("R5 clear value", rdReg, 32'h10024);

    // R10: outputs hold during the write cycle
    @(negedge clk);
    wrEn = 1'b1; wrSel = 2'd0; wrData = 32'h0FFFF;
    #3;
    check("R10 old reg in write cycle", rdReg, 32'h10024);
    check("R10 old pending", {15'd0, pending}, {15'd0, modelPend(17'h10024, 4'd3)});
    expReg = 17'h0FFFF;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    checkAll("R10 after edge");

    // R9: timer pulse alone and racing writes
    doWrite(2'd0, 32'h0, 1'b0);
    @(negedge clk); sysTickHit = 1'b1; expReg[16] = 1'b1;
    @(negedge clk); sysTickHit = 1'b0;
    checkAll("R9 pulse alone");
    check("R9 bit16", rdReg, 32'h10000);
    doWrite(2'd2, 32'h10000, 1'b1);
    check("R9 clear race", rdReg, 32'h10000);
    doWrite(2'd0, 32'h00002, 1'b1);
    check("R9 direct race", rdReg, 32'h10002);
    doWrite(2'd3, 32'd15, 1'b1);
    checkAll("R9 level write race");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule